// File: doc/BRIEF.md
# JTAG-to-SPI Bridge Proxy

This block sits behind a user data register of a boundary-scan TAP and gives a debug host access to an SPI flash through the JTAG chain. Everything runs on TCK. While the TAP is in its data-shift state, the bridge looks at the TDI stream. It ignores zeros until it sees a first 1, which it treats as a start marker. It then reads a 32-bit cycle count, most significant bit first, and runs exactly that many SPI clock cycles with chip select low. During those cycles each TDI bit goes out on MOSI, and each MISO bit comes back on TDO.

Framing is carried in-band, and the bridge acts as a one-bit data register. The host therefore needs no knowledge of how many bypassed TAPs sit ahead of the bridge. It pads the front of the scan with zeros and the tail with extra cycles, so that the returned data can ripple through the bypass registers behind the bridge. Every access is preceded by an IR scan. An IR scan, a capture indication or leaving the shift state returns the bridge to waiting for a marker. If a transfer is still in progress at that moment, it is aborted.

Top module: `jtag_spi_bridge`

## Requirements
- R1: While reset is asserted, spi_cs_n is 1, and spi_sck, spi_mosi and tdo are 0.
- R2: While waiting for a marker, a shift cycle with tdi = 0 leaves the bridge waiting. The bridge produces no SPI clock and holds spi_cs_n at 1.
- R3: The first shift cycle with tdi = 1 while waiting is a marker. The next 32 shift cycles load the cycle count, most significant bit first. No SPI clock occurs during the marker or the count.
- R4: For a count N > 0, spi_sck pulses exactly N times, one pulse per TCK cycle on the rising edge of TCK. spi_cs_n falls on the TCK falling edge after the last count bit and rises on the TCK falling edge after the N-th pulse.
- R5: While chip select is asserted, spi_mosi equals tdi, so the bit shifted in a data cycle is seen by the flash on that cycle's SPI rising edge. Outside a transfer, spi_mosi is 0.
- R6: spi_miso is sampled on each SPI rising edge. The sampled value appears on tdo after that TCK rising edge and holds until the next one, which is a one-bit data register delay.
- R7: tdo is 0 after any TCK rising edge that is not a counted data cycle.
- R8: After N cycles, further shift cycles, including ones with tdi = 1, produce no SPI clock and leave spi_cs_n at 1 until the shift state is left.
- R9: A count of 0 completes with no SPI clock, and spi_cs_n never falls.
- R10: A TCK rising edge with sel_shift = 0 aborts a transfer: no SPI pulse occurs on that edge, spi_cs_n is 1 from the next falling edge, and the bridge waits for a new marker.
- R11: A TCK rising edge with capture = 1 aborts in the same way as R10, even if sel_shift is 1, and the bridge waits for a new marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | TAP test clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on TCK |
| sel_shift | input | 1 | Bridge register selected and TAP in data-shift state |
| capture | input | 1 | Capture or reset indication from the TAP; returns the bridge to waiting |
| tdi | input | 1 | Serial data from the chain |
| tdo | output | 1 | Serial data toward the chain (returned MISO) |
| spi_sck | output | 1 | SPI clock, gated from TCK |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | SPI data to the flash |
| spi_miso | input | 1 | SPI data from the flash |

## Verification
The bench runs transfers with varying numbers of leading zeros and several counts against a flash model that counts clock pulses and records MOSI. A bridge that treated stale zeros or the length field as payload would show extra pulses, and an off-by-one count would give one pulse too many or too few. Trailing ones after a completed transfer are sent to catch a bridge that re-arms on them, and a zero count is sent to catch a chip-select glitch. Aborts by leaving the shift state and by capture are exercised mid-transfer. A design that missed an abort would keep clocking the flash, or would fail to start the transfer that follows.

// File: rtl/jsb_pkg.sv
package jsb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LEN  = 2'd1,
    ST_DATA = 2'd2,
    ST_DONE = 2'd3
  } jsb_state_e;
endpackage

// File: rtl/jsb_rst_sync.sv
module jsb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_ns = sync_q[STAGES-1];
endmodule

// File: rtl/jsb_frame_ctl.sv
module jsb_frame_ctl
  import jsb_pkg::*;
#(
  parameter int LEN_W = 32
) (
  input  logic       clk,
  input  logic       rst_ns,
  input  logic       shift_en,
  input  logic       cap,
  input  logic       tdi,
  output jsb_state_e state,
  output logic       in_data,
  output logic       data_cyc
);
  localparam int BW = $clog2(LEN_W);

  jsb_state_e        st_n;
  logic [LEN_W-1:0]  cnt_q, cnt_n, shifted;
  logic [BW-1:0]     idx_q, idx_n;
  logic              last_bit, dp_en;

  assign shifted  = {cnt_q[LEN_W-2:0], tdi};
  assign last_bit = (idx_q == BW'(LEN_W - 1));
  assign in_data  = (state == ST_DATA);
  assign data_cyc = in_data && shift_en && !cap;
  assign dp_en    = shift_en && !cap;

  always_comb begin
    st_n  = state;
    cnt_n = cnt_q;
    idx_n = idx_q;
    if (!shift_en || cap) begin
      st_n = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: begin
          if (tdi) begin
            st_n  = ST_LEN;
            idx_n = '0;
          end
        end
        ST_LEN: begin
          cnt_n = shifted;
          idx_n = idx_q + BW'(1);
          if (last_bit) st_n = (shifted == '0) ? ST_DONE : ST_DATA;
        end
        ST_DATA: begin
          cnt_n = cnt_q - LEN_W'(1);
          if (cnt_q == LEN_W'(1)) st_n = ST_DONE;
        end
        default: st_n = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) state <= ST_IDLE;
    else         state <= st_n;
  end

  always_ff @(posedge clk) begin
    if (dp_en) begin
      cnt_q <= cnt_n;
      idx_q <= idx_n;
    end
  end
endmodule

// File: rtl/jsb_spi_gate.sv
module jsb_spi_gate (
  input  logic clk,
  input  logic rst_ns,
  input  logic in_data,
  input  logic shift_en,
  input  logic cap,
  input  logic tdi,
  output logic sck,
  output logic cs_n,
  output logic mosi
);
  logic act_q;

  // Updated while TCK is low, so the clock gate below cannot glitch.
  always_ff @(negedge clk or negedge rst_ns) begin
    if (!rst_ns) act_q <= 1'b0;
    else         act_q <= in_data;
  end

  assign sck  = clk & act_q & shift_en & ~cap;
  assign cs_n = ~act_q;
  assign mosi = act_q & tdi;
endmodule

// File: rtl/jsb_miso_cap.sv
module jsb_miso_cap (
  input  logic clk,
  input  logic rst_ns,
  input  logic data_cyc,
  input  logic miso,
  output logic tdo
);
  logic dr_q, dr_n;

  assign dr_n = data_cyc ? miso : 1'b0;

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) dr_q <= 1'b0;
    else         dr_q <= dr_n;
  end

  assign tdo = dr_q;
endmodule

// File: rtl/jtag_spi_bridge.sv
module jtag_spi_bridge
  import jsb_pkg::*;
#(
  parameter int LEN_W = 32
) (
  input  logic tck,
  input  logic rst_n,
  input  logic sel_shift,
  input  logic capture,
  input  logic tdi,
  output logic tdo,
  output logic spi_sck,
  output logic spi_cs_n,
  output logic spi_mosi,
  input  logic spi_miso
);
  logic       rst_ns;
  jsb_state_e frm_state;
  logic       in_data, data_cyc;

  jsb_rst_sync #(.STAGES(2)) u_rst (
    .clk(tck), .rst_n(rst_n), .rst_ns(rst_ns)
  );

  jsb_frame_ctl #(.LEN_W(LEN_W)) u_ctl (
    .clk(tck), .rst_ns(rst_ns), .shift_en(sel_shift), .cap(capture),
    .tdi(tdi), .state(frm_state), .in_data(in_data), .data_cyc(data_cyc)
  );

  jsb_spi_gate u_gate (
    .clk(tck), .rst_ns(rst_ns), .in_data(in_data), .shift_en(sel_shift),
    .cap(capture), .tdi(tdi), .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi)
  );

  jsb_miso_cap u_cap (
    .clk(tck), .rst_ns(rst_ns), .data_cyc(data_cyc), .miso(spi_miso), .tdo(tdo)
  );
endmodule

// File: rtl/jsb_checker.sv
module jsb_checker
  import jsb_pkg::*;
(
  input logic       tck,
  input logic       rst_ns,
  input logic       sel_shift,
  input logic       capture,
  input logic       tdi,
  input logic       tdo,
  input logic       spi_cs_n,
  input jsb_state_e frm_state
);
  a_r2_zero_ignored: assert property (@(posedge tck) disable iff (!rst_ns)
    (frm_state == ST_IDLE && sel_shift && !capture && !tdi) |=>
      (frm_state == ST_IDLE && spi_cs_n));

  a_r3_marker_starts: assert property (@(posedge tck) disable iff (!rst_ns)
    (frm_state == ST_IDLE && sel_shift && !capture && tdi) |=> (frm_state == ST_LEN));

  a_r4_cs_released: assert property (@(posedge tck) disable iff (!rst_ns)
    ($past(frm_state) == ST_DONE && frm_state == ST_DONE) |-> spi_cs_n);

  a_r7_tdo_quiet: assert property (@(posedge tck) disable iff (!rst_ns)
    !(frm_state == ST_DATA && sel_shift && !capture) |=> !tdo);

  a_r10_shift_abort: assert property (@(posedge tck) disable iff (!rst_ns)
    !sel_shift |=> (frm_state == ST_IDLE));

  a_r11_capture_abort: assert property (@(posedge tck) disable iff (!rst_ns)
    capture |=> (frm_state == ST_IDLE));
endmodule

bind jtag_spi_bridge jsb_checker u_chk (
  .tck(tck), .rst_ns(rst_ns), .sel_shift(sel_shift), .capture(capture),
  .tdi(tdi), .tdo(tdo), .spi_cs_n(spi_cs_n), .frm_state(frm_state)
);

// File: tb/jtag_spi_bridge_test.sv
module jtag_spi_bridge_test;
  logic tck = 1'b0;
  logic rst_n, sel_shift, capture, tdi, spi_miso;
  logic tdo, spi_sck, spi_cs_n, spi_mosi;

  int checks = 0;
  int fails  = 0;

  always #2 tck = ~tck;

  jtag_spi_bridge uut (
    .tck(tck), .rst_n(rst_n), .sel_shift(sel_shift), .capture(capture),
    .tdi(tdi), .tdo(tdo), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  // Flash model: counts clock pulses, records MOSI, returns a pattern.
  int          sck_cnt = 0;
  int          cs_falls = 0;
  logic [15:0] rx = '0;
  logic [15:0] mpat = '0;

  always @(posedge spi_sck) begin
    if (sck_cnt < 16) rx[sck_cnt[3:0]] <= spi_mosi;
    sck_cnt <= sck_cnt + 1;
  end
  always @(negedge spi_cs_n) cs_falls <= cs_falls + 1;
  assign spi_miso = (sck_cnt < 16) ? mpat[sck_cnt[3:0]] : 1'b0;

  typedef struct packed {
    logic [3:0]  lead;
    logic [4:0]  len;
    logic [15:0] opat;
    logic [15:0] mpat;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{lead: 4'd0, len: 5'd8,  opat: 16'h00A5, mpat: 16'h003C},
    '{lead: 4'd3, len: 5'd1,  opat: 16'h0001, mpat: 16'h0001},
    '{lead: 4'd9, len: 5'd16, opat: 16'hC3E1, mpat: 16'h5A96},
    '{lead: 4'd1, len: 5'd5,  opat: 16'h0016, mpat: 16'h0009},
    '{lead: 4'd6, len: 5'd0,  opat: 16'h0000, mpat: 16'hFFFF}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive on the falling edge, sample 1 ns after the rising edge.
  task automatic cyc(input logic b, input logic s, input logic c);
    @(negedge tck);
    tdi = b; sel_shift = s; capture = c;
    @(posedge tck);
    #1;
  endtask

  task automatic send_header(input int lead, input int len);
    for (int i = 0; i < lead; i++) cyc(1'b0, 1'b1, 1'b0);
    cyc(1'b1, 1'b1, 1'b0);
    for (int i = 31; i >= 0; i--) cyc(len[i], 1'b1, 1'b0);
  endtask

  task automatic xfer(input vec_t v);
    logic        tdo_bad, cs_bad;
    logic [15:0] mask;
    sck_cnt = 0; cs_falls = 0; mpat = v.mpat;
    tdo_bad = 1'b0; cs_bad = 1'b0;
    for (int i = 0; i < int'(v.lead); i++) cyc(1'b0, 1'b1, 1'b0);
    check("R2 zeros ignored", {31'd0, spi_cs_n} | (sck_cnt << 1), 32'd1);
    send_header(0, int'(v.len));
    check("R3 no clock in header", sck_cnt, 0);
    for (int k = 0; k < int'(v.len); k++) begin
      cyc(v.opat[k], 1'b1, 1'b0);
      if (tdo !== v.mpat[k]) tdo_bad = 1'b1;
      if (spi_cs_n !== 1'b0) cs_bad = 1'b1;
    end
    check("R6 tdo returns miso", {31'd0, tdo_bad}, 0);
    check("R4 cs low in data", {31'd0, cs_bad}, 0);
    for (int i = 0; i < 4; i++) cyc(1'b1, 1'b1, 1'b0);
    check("R4 R9 pulse count", sck_cnt, int'(v.len));
    check("R8 cs high after", {31'd0, spi_cs_n}, 1);
    check("R7 tdo zero after", {31'd0, tdo}, 0);
    check("R9 cs fall count", cs_falls, (v.len != 0) ? 1 : 0);
    mask = (v.len >= 16) ? 16'hFFFF : ((16'd1 << v.len) - 16'd1);
    check("R5 mosi data", rx & mask, v.opat & mask);
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sel_shift = 1'b1; capture = 1'b0; tdi = 1'b1;
    repeat (4) @(posedge tck);
    #1;
    check("R1 reset cs_n", {31'd0, spi_cs_n}, 1);
    check("R1 reset sck/mosi/tdo", {29'd0, spi_sck, spi_mosi, tdo}, 0);
    @(negedge tck); sel_shift = 1'b0; tdi = 1'b0;
    rst_n = 1'b1;
    repeat (4) cyc(1'b0, 1'b0, 1'b0);

    foreach (VECS[i]) xfer(VECS[i]);

    // R10: leave shift after 5 of 12 data cycles.
    sck_cnt = 0; mpat = 16'h0FFF;
    send_header(2, 12);
    for (int k = 0; k < 5; k++) cyc(1'b1, 1'b1, 1'b0);
    cyc(1'b1, 1'b0, 1'b0);
    check("R10 no pulse on exit edge", sck_cnt, 5);
    cyc(1'b0, 1'b0, 1'b0);
    check("R10 cs released", {31'd0, spi_cs_n}, 1);
    xfer('{lead: 4'd2, len: 5'd3, opat: 16'h0005, mpat: 16'h0006});

    // R11: capture mid-transfer with shift still high.
    sck_cnt = 0; mpat = 16'h0000;
    send_header(1, 10);
    for (int k = 0; k < 4; k++) cyc(1'b0, 1'b1, 1'b0);
    cyc(1'b1, 1'b1, 1'b1);
    cyc(1'b0, 1'b1, 1'b0);
    cyc(1'b0, 1'b1, 1'b0);
    check("R11 capture stops clock", sck_cnt, 4);
    check("R11 cs released", {31'd0, spi_cs_n}, 1);
    cyc(1'b0, 1'b0, 1'b0);
    xfer('{lead: 4'd0, len: 5'd2, opat: 16'h0002, mpat: 16'h0001});

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule